// File: doc/BRIEF.md
# Configurable Serial Shift Port

This block is a small serial engine built from one shift register and one edge counter. The same core can serve a three-wire link (separate data-out, data-in and clock pins) or a two-wire open-drain link (shared data and clock lines). A wire-mode field selects which pins the core takes over. A clock-source field selects what advances the core: a software strobe, a timer compare pulse, or the external clock pin. For the external pin, either the rising or the falling edge can be chosen as the sampling edge.

Software frames the bytes around the core. It loads the shift register, reads received bits and counts, and clears two sticky flags. The start flag reports that the data line fell while the clock line stayed high. The overflow flag reports that the counter wrapped. In the two-wire modes the block pulls the clock line low while the start flag is set. In the stretching mode it also pulls the clock line low while the overflow flag is set, so the bus is held still until software has dealt with the event.

A start-detector state machine has three states:
- `SD_OFF`: the port is disabled.
- `SD_WATCH`: the detector is armed.
- `SD_HELD`: a start was seen and the flag is set.

Its transitions are:
- Any state goes to `SD_OFF` while the wire mode is 00.
- `SD_OFF` goes to `SD_WATCH` once the port is enabled.
- `SD_OFF` or `SD_WATCH` goes to `SD_HELD` when a start is detected.
- `SD_HELD` goes to `SD_WATCH` when software clears the flag and no new start occurs in the same cycle.

Top module: `ssp_port`

## Requirements
- R1: After reset, the shift register, the counter, the start flag and the overflow flag are all zero.
- R2: With wire mode 00, neither line is pulled low, the start flag stays 0 from the next cycle on, and `dout_val` equals `port_dat`.
- R3: With wire mode 01, `dout_val` is the data-out bit and `dout_oe` equals `dir_dat`. The data-out bit is the shift register MSB, taken through the output latch when the clock is external.
- R4: With wire mode 10 or 11, `sda_pull_low` is 1 exactly when `dir_dat` is 1 and either the data-out bit or `port_dat` is 0. In these modes `dout_oe` is 0.
- R5: With wire mode 10 or 11, `scl_pull_low` is 1 exactly when `dir_clk` is 1 and any of the following holds:
  - `port_clk` is 0;
  - the start flag is set;
  - the wire mode is 11 and the overflow flag is set.
- R6: With a nonzero wire mode, the start flag is set one cycle after a cycle in which the data pin goes from 1 to 0 while the clock pin is 1 in both cycles. A `clr_start` pulse clears the flag, but a new start in the same cycle wins.
- R7: Each counter event adds one to the 4-bit counter. The event after a count of 15 wraps the counter to 0 and sets the overflow flag. A `clr_ovf` pulse clears the flag, but a set in the same cycle wins.
- R8: With clock source 00, each cycle with `clk_strobe` high shifts `dat_pin_in` into the LSB and advances the counter. Without `clk_strobe`, the counter holds.
- R9: With clock source 01, each `timer_tick` shifts and counts, and `clk_strobe` is ignored.
- R10: Clock source 10 samples on a rising clock-pin edge and updates the output latch on a falling edge. Clock source 11 does the reverse. With sources 00 and 01 the data-out bit follows the MSB at once.
- R11: With an external source, `clk_strobe` selects what the counter counts. When it is 0, the counter counts both edges of the clock pin. When it is 1, the counter counts only `toggle_strobe` pulses.
- R12: `pullups_en` is 0 in wire modes 10 and 11, and 1 otherwise.
- R13: `wr_en` loads `wr_data` into the shift register and takes priority over a shift in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wire_mode | input | 2 | 00 off, 01 three-wire, 10 two-wire, 11 two-wire with overflow stretch |
| clk_src | input | 2 | 00 strobe, 01 timer, 10 external rising sample, 11 external falling sample |
| clk_strobe | input | 1 | Strobe pulse for source 00; counter select for external sources |
| timer_tick | input | 1 | Timer compare pulse |
| toggle_strobe | input | 1 | Software toggle pulse counted when selected |
| wr_en | input | 1 | Load the shift register |
| wr_data | input | 8 | Value to load |
| clr_start | input | 1 | Clear the start flag |
| clr_ovf | input | 1 | Clear the overflow flag |
| dat_pin_in | input | 1 | Sampled data/SDA pin level |
| clk_pin_in | input | 1 | Sampled clock/SCL pin level |
| port_dat | input | 1 | Port output bit for the data pin |
| port_clk | input | 1 | Port output bit for the clock pin |
| dir_dat | input | 1 | Driver enable for the data pin |
| dir_clk | input | 1 | Driver enable for the clock pin |
| shift_q | output | 8 | Shift register contents |
| count_q | output | 4 | Edge counter |
| start_flag | output | 1 | Sticky start-condition flag |
| ovf_flag | output | 1 | Sticky overflow flag |
| dout_val | output | 1 | Value for the data-out pin |
| dout_oe | output | 1 | Push-pull enable for the data-out pin |
| sda_pull_low | output | 1 | Pull the data line low |
| scl_pull_low | output | 1 | Pull the clock line low |
| pullups_en | output | 1 | Internal pull-ups allowed |

## Verification
The checker enforces the following on every cycle:
- the line-hold rules for a pending start and for a stretched overflow;
- the silence of both open-drain drives in mode 00;
- that the start flag only rises after the data line was seen low with the clock high;
- that the overflow flag only rises with the counter at zero;
- that pull-ups are off in the two-wire modes;
- that the counter or register holds when the selected internal source is idle.

Only the bench scenarios can show the rest, because each of these needs a whole stimulus history:
- the bit order of shifted data;
- the half-period offset of the output latch for each external edge choice;
- counting of toggle pulses instead of pin edges;
- the clear-versus-set priority of both flags.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
    typedef enum logic [1:0] {
        WM_OFF         = 2'b00,
        WM_THREE       = 2'b01,
        WM_TWO         = 2'b10,
        WM_TWO_STRETCH = 2'b11
    } wire_mode_e;

    typedef enum logic [1:0] {
        CS_STROBE   = 2'b00,
        CS_TIMER    = 2'b01,
        CS_EXT_RISE = 2'b10,
        CS_EXT_FALL = 2'b11
    } clk_src_e;

    typedef enum logic [1:0] {
        SD_OFF   = 2'b00,
        SD_WATCH = 2'b01,
        SD_HELD  = 2'b10
    } sdet_state_e;
endpackage

// File: rtl/ssp_pin_edges.sv
module ssp_pin_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic dat_in,
    input  logic clk_in,
    output logic dat_fall,
    output logic clk_rise,
    output logic clk_fall,
    output logic clk_hi_both
);
    logic dat_q;
    logic clk_q;

    // Idle bus level is high on both lines
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dat_q <= 1'b1;
            clk_q <= 1'b1;
        end else begin
            dat_q <= dat_in;
            clk_q <= clk_in;
        end
    end

    always_comb begin
        dat_fall    = dat_q & ~dat_in;
        clk_rise    = ~clk_q & clk_in;
        clk_fall    = clk_q & ~clk_in;
        clk_hi_both = clk_q & clk_in;
    end
endmodule

// File: rtl/ssp_start_fsm.sv
module ssp_start_fsm
    import ssp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic start_seen,
    input  logic clr,
    output logic held
);
    sdet_state_e state_q;
    sdet_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SD_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (!enable) begin
            state_d = SD_OFF;
        end else begin
            unique case (state_q)
                SD_OFF:   state_d = start_seen ? SD_HELD : SD_WATCH;
                SD_WATCH: state_d = start_seen ? SD_HELD : SD_WATCH;
                SD_HELD:  state_d = (clr && !start_seen) ? SD_WATCH : SD_HELD;
                default:  state_d = SD_OFF;
            endcase
        end
    end

    always_comb begin
        held = (state_q == SD_HELD);
    end
endmodule

// File: rtl/ssp_shift_core.sv
module ssp_shift_core #(
    parameter int W  = 8,
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [W-1:0]  wr_data,
    input  logic          shift_ev,
    input  logic          count_ev,
    input  logic          latch_ev,
    input  logic          use_latch,
    input  logic          din,
    input  logic          clr_ovf,
    output logic [W-1:0]  sreg_q,
    output logic [CW-1:0] cnt_q,
    output logic          ovf_q,
    output logic          out_bit
);
    localparam int MSB = W - 1;
    localparam logic [CW-1:0] CNT_TOP = {CW{1'b1}};

    logic latch_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg_q  <= '0;
            latch_q <= 1'b0;
        end else begin
            if (latch_ev) latch_q <= sreg_q[MSB];
            if (wr_en)         sreg_q <= wr_data;
            else if (shift_ev) sreg_q <= {sreg_q[MSB-1:0], din};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            if (count_ev) cnt_q <= cnt_q + 1'b1;
            if (count_ev && cnt_q == CNT_TOP) ovf_q <= 1'b1;
            else if (clr_ovf)                 ovf_q <= 1'b0;
        end
    end

    always_comb begin
        out_bit = use_latch ? latch_q : sreg_q[MSB];
    end
endmodule

// File: rtl/ssp_port.sv
module ssp_port
    import ssp_pkg::*;
#(
    parameter int W  = 8,
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    wire_mode,
    input  logic [1:0]    clk_src,
    input  logic          clk_strobe,
    input  logic          timer_tick,
    input  logic          toggle_strobe,
    input  logic          wr_en,
    input  logic [W-1:0]  wr_data,
    input  logic          clr_start,
    input  logic          clr_ovf,
    input  logic          dat_pin_in,
    input  logic          clk_pin_in,
    input  logic          port_dat,
    input  logic          port_clk,
    input  logic          dir_dat,
    input  logic          dir_clk,
    output logic [W-1:0]  shift_q,
    output logic [CW-1:0] count_q,
    output logic          start_flag,
    output logic          ovf_flag,
    output logic          dout_val,
    output logic          dout_oe,
    output logic          sda_pull_low,
    output logic          scl_pull_low,
    output logic          pullups_en
);
    wire_mode_e wm;
    clk_src_e   cs;
    logic dat_fall, clk_rise, clk_fall, clk_hi_both;
    logic shift_ev, count_ev, latch_ev, ext_src, out_bit, two_wire;

    assign wm = wire_mode_e'(wire_mode);
    assign cs = clk_src_e'(clk_src);

    ssp_pin_edges u_edges (
        .clk(clk), .rst_n(rst_n), .dat_in(dat_pin_in), .clk_in(clk_pin_in),
        .dat_fall(dat_fall), .clk_rise(clk_rise), .clk_fall(clk_fall),
        .clk_hi_both(clk_hi_both)
    );

    ssp_start_fsm u_start (
        .clk(clk), .rst_n(rst_n), .enable(wm != WM_OFF),
        .start_seen(dat_fall & clk_hi_both), .clr(clr_start), .held(start_flag)
    );

    always_comb begin
        ext_src  = 1'b0;
        shift_ev = 1'b0;
        latch_ev = 1'b0;
        unique case (cs)
            CS_STROBE:   shift_ev = clk_strobe;
            CS_TIMER:    shift_ev = timer_tick;
            CS_EXT_RISE: begin ext_src = 1'b1; shift_ev = clk_rise; latch_ev = clk_fall; end
            CS_EXT_FALL: begin ext_src = 1'b1; shift_ev = clk_fall; latch_ev = clk_rise; end
            default:     shift_ev = 1'b0;
        endcase
        if (ext_src) count_ev = clk_strobe ? toggle_strobe : (clk_rise | clk_fall);
        else         count_ev = shift_ev;
    end

    ssp_shift_core #(.W(W), .CW(CW)) u_core (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .shift_ev(shift_ev), .count_ev(count_ev), .latch_ev(latch_ev),
        .use_latch(ext_src), .din(dat_pin_in), .clr_ovf(clr_ovf),
        .sreg_q(shift_q), .cnt_q(count_q), .ovf_q(ovf_flag), .out_bit(out_bit)
    );

    always_comb begin
        two_wire     = (wm == WM_TWO) || (wm == WM_TWO_STRETCH);
        dout_val     = (wm == WM_THREE) ? out_bit : port_dat;
        dout_oe      = dir_dat & ~two_wire;
        pullups_en   = ~two_wire;
        sda_pull_low = two_wire & dir_dat & (~out_bit | ~port_dat);
        scl_pull_low = two_wire & dir_clk &
                       (~port_clk | start_flag | ((wm == WM_TWO_STRETCH) & ovf_flag));
    end
endmodule

// File: rtl/ssp_port_chk.sv
module ssp_port_chk #(
    parameter int W  = 8,
    parameter int CW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    wire_mode,
    input logic [1:0]    clk_src,
    input logic          clk_strobe,
    input logic          timer_tick,
    input logic          wr_en,
    input logic          dat_pin_in,
    input logic          clk_pin_in,
    input logic          dir_clk,
    input logic [W-1:0]  shift_q,
    input logic [CW-1:0] count_q,
    input logic          start_flag,
    input logic          ovf_flag,
    input logic          sda_pull_low,
    input logic          scl_pull_low,
    input logic          pullups_en
);
    // R2
    mode_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wire_mode == 2'b00) |-> (!sda_pull_low && !scl_pull_low));
    // R2
    mode_off_noflag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wire_mode == 2'b00) |=> !start_flag);
    // R5
    start_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_flag && wire_mode[1] && dir_clk) |-> scl_pull_low);
    // R5
    ovf_stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wire_mode == 2'b11 && ovf_flag && dir_clk) |-> scl_pull_low);
    // R6
    start_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(start_flag) |-> $past(!dat_pin_in && clk_pin_in));
    // R7
    ovf_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> (count_q == '0));
    // R8
    strobe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_src == 2'b00 && !clk_strobe) |=> $stable(count_q));
    // R9
    timer_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_src == 2'b01 && !timer_tick && !wr_en) |=> $stable(shift_q));
    // R12
    pullup_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wire_mode[1] |-> !pullups_en);
endmodule

bind ssp_port ssp_port_chk #(.W(W), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .wire_mode(wire_mode), .clk_src(clk_src),
    .clk_strobe(clk_strobe), .timer_tick(timer_tick), .wr_en(wr_en),
    .dat_pin_in(dat_pin_in), .clk_pin_in(clk_pin_in), .dir_clk(dir_clk),
    .shift_q(shift_q), .count_q(count_q), .start_flag(start_flag),
    .ovf_flag(ovf_flag), .sda_pull_low(sda_pull_low),
    .scl_pull_low(scl_pull_low), .pullups_en(pullups_en)
);

// File: tb/ssp_port_test.sv
`timescale 1ns/1ps
module ssp_port_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] wire_mode = 2'b00, clk_src = 2'b00;
    logic clk_strobe = 0, timer_tick = 0, toggle_strobe = 0, wr_en = 0;
    logic [7:0] wr_data = 8'h00;
    logic clr_start = 0, clr_ovf = 0, dat_pin_in = 1, clk_pin_in = 1;
    logic port_dat = 1, port_clk = 1, dir_dat = 0, dir_clk = 0;
    logic [7:0] shift_q;
    logic [3:0] count_q;
    logic start_flag, ovf_flag, dout_val, dout_oe, sda_pull_low, scl_pull_low, pullups_en;

    int n_vec = 0, n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    ssp_port uut (.*);

    // Behavioural reference
    int  m_sreg, m_cnt;
    bit  m_ovf, m_start, m_latch, m_pdat, m_pclk;
    bit  e_rise, e_fall, e_samp, e_cnt, e_opp;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_sreg = 0; m_cnt = 0; m_ovf = 0; m_start = 0; m_latch = 0;
            m_pdat = 1; m_pclk = 1;
        end else begin
            e_rise = clk_pin_in && !m_pclk;
            e_fall = !clk_pin_in && m_pclk;
            case (clk_src)
                2'd0: e_samp = clk_strobe;
                2'd1: e_samp = timer_tick;
                2'd2: e_samp = e_rise;
                default: e_samp = e_fall;
            endcase
            e_opp = (clk_src == 2'd2) ? e_fall : (clk_src == 2'd3) ? e_rise : 1'b0;
            e_cnt = !clk_src[1] ? e_samp : (clk_strobe ? toggle_strobe : (e_rise || e_fall));
            if (e_opp) m_latch = m_sreg[7];
            if (wr_en) m_sreg = wr_data;
            else if (e_samp) m_sreg = ((m_sreg * 2) + dat_pin_in) % 256;
            if (clr_ovf) m_ovf = 0;
            if (e_cnt) begin
                if (m_cnt == 15) begin m_cnt = 0; m_ovf = 1; end
                else m_cnt = m_cnt + 1;
            end
            if (wire_mode == 2'b00) m_start = 0;
            else begin
                if (clr_start) m_start = 0;
                if (m_pdat && !dat_pin_in && m_pclk && clk_pin_in) m_start = 1;
            end
            m_pdat = dat_pin_in; m_pclk = clk_pin_in;
        end
    end

    task automatic cmp(input string req, input string what, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
        end
    endtask

    // Compare every output on every cycle
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit ob, two;
            ob  = clk_src[1] ? m_latch : m_sreg[7];
            two = wire_mode[1];
            cmp("R13/R8", "shift_q", shift_q, m_sreg);
            cmp("R7", "count_q", count_q, m_cnt);
            cmp("R7", "ovf_flag", ovf_flag, m_ovf);
            cmp("R6", "start_flag", start_flag, m_start);
            cmp("R3", "dout_val", dout_val, (wire_mode == 2'b01) ? ob : port_dat);
            cmp("R3", "dout_oe", dout_oe, dir_dat && !two);
            cmp("R4", "sda_pull_low", sda_pull_low, two && dir_dat && (!ob || !port_dat));
            cmp("R5", "scl_pull_low", scl_pull_low,
                two && dir_clk && (!port_clk || m_start || (wire_mode == 2'b11 && m_ovf)));
            cmp("R12", "pullups_en", pullups_en, !two);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pulse_strobe(input bit d);
        dat_pin_in = d; clk_strobe = 1; cyc(1); clk_strobe = 0;
    endtask

    task automatic ext_bit(input bit d);
        dat_pin_in = d; clk_pin_in = 0; cyc(2);
        clk_pin_in = 1; cyc(2);
    endtask

    initial begin
        #(200000 * 4);
        n_bad++;
        $display("FAIL watchdog expired");
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        cyc(3);
        rst_n = 1;
        cyc(1);
        // R1 reset state
        cmp("R1", "shift reset", shift_q, 0);
        cmp("R1", "count reset", count_q, 0);
        cmp("R1", "flags reset", {start_flag, ovf_flag}, 0);

        // R2 disabled mode: drivers quiet, start ignored
        dir_dat = 1; dir_clk = 1; port_dat = 0; port_clk = 0;
        cyc(1);
        cmp("R2", "no pull in mode 00", {sda_pull_low, scl_pull_low}, 0);
        cmp("R2", "dout_val follows port", dout_val, 0);
        port_dat = 1; port_clk = 1;
        dat_pin_in = 0; cyc(2);
        cmp("R2", "start ignored", start_flag, 0);
        dat_pin_in = 1; cyc(2);

        // R8 software strobe, three-wire, shift 0xA5 MSB first
        wire_mode = 2'b01; clk_src = 2'b00;
        clk_pin_in = 0; cyc(1);
        for (int i = 7; i >= 0; i--) pulse_strobe(8'hA5 >> i);
        cmp("R8", "strobe shifted byte", shift_q, 8'hA5);
        cmp("R8", "strobe count", count_q, 8);
        cmp("R3", "dout is MSB", dout_val, 1);
        for (int i = 0; i < 8; i++) pulse_strobe(i[0]);
        cmp("R7", "wrap count", count_q, 0);
        cmp("R7", "overflow set", ovf_flag, 1);
        clr_ovf = 1; clk_strobe = 1; cyc(1); clk_strobe = 0; clr_ovf = 0;
        cmp("R7", "clear loses to no-set", ovf_flag, 0);

        // R9 timer source, strobe ignored
        clk_src = 2'b01;
        clk_strobe = 1; cyc(2); clk_strobe = 0;
        cmp("R9", "strobe ignored count", count_q, 1);
        dat_pin_in = 1; timer_tick = 1; cyc(3); timer_tick = 0;
        cmp("R9", "timer counted", count_q, 4);

        // R13 load beats shift
        wr_data = 8'h3C; wr_en = 1; timer_tick = 1; cyc(1); wr_en = 0; timer_tick = 0;
        cmp("R13", "load priority", shift_q, 8'h3C);

        // R10 external rising sample, falling latch
        clr_ovf = 1; cyc(1); clr_ovf = 0;
        clk_pin_in = 1; clk_src = 2'b10; cyc(1);
        wr_data = 8'h80; wr_en = 1; cyc(1); wr_en = 0;
        cmp("R10", "latch not yet updated", dout_val, 0);
        clk_pin_in = 0; cyc(1);
        cmp("R10", "latch on falling edge", dout_val, 1);
        clk_pin_in = 1; cyc(1);

        // R7/R5 two-wire stretch: 8 bits on external clock
        wire_mode = 2'b11;
        for (int i = 7; i >= 0; i--) ext_bit(8'h5A >> i);
        cmp("R10", "external rise byte", shift_q, 8'h5A);
        cmp("R5", "stretch hold", scl_pull_low, ovf_flag);
        clr_ovf = 1; cyc(1); clr_ovf = 0;
        cmp("R5", "stretch released", scl_pull_low, 0);

        // R10 falling sample source
        clk_src = 2'b11; wire_mode = 2'b01;
        for (int i = 7; i >= 0; i--) ext_bit(8'hC3 >> i);
        cmp("R10", "external fall sample", shift_q[0], 1);

        // R11 toggle counting
        clk_strobe = 1; cyc(1);
        for (int i = 0; i < 3; i++) begin clk_pin_in = ~clk_pin_in; cyc(1); end
        cmp("R11", "pin edges not counted", count_q, m_cnt);
        toggle_strobe = 1; cyc(5); toggle_strobe = 0; clk_strobe = 0;
        clk_pin_in = 1; cyc(2);

        // R6 start detection in two-wire mode with hold
        wire_mode = 2'b10; dat_pin_in = 1; cyc(2);
        dat_pin_in = 0; cyc(1);
        cmp("R6", "start flagged", start_flag, 1);
        cmp("R5", "start holds clock", scl_pull_low, 1);
        cmp("R12", "pullups off", pullups_en, 0);
        clr_start = 1; cyc(1); clr_start = 0;
        cmp("R6", "start cleared", start_flag, 0);
        dat_pin_in = 1; cyc(1);
        dat_pin_in = 0; clr_start = 1; cyc(1); clr_start = 0;
        cmp("R6", "set beats clear", start_flag, 1);

        // R4 open-drain data
        clr_start = 1; cyc(1); clr_start = 0;
        clk_src = 2'b00; wr_data = 8'h00; wr_en = 1; cyc(1); wr_en = 0;
        cmp("R4", "data low pulls line", sda_pull_low, 1);
        wr_data = 8'hFF; wr_en = 1; cyc(1); wr_en = 0;
        cmp("R4", "data high releases", sda_pull_low, 0);
        cmp("R4", "no push-pull", dout_oe, 0);
        cyc(3);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule